// File: doc/BRIEF.md
# Single-Wire Slave Slot Decoder

This block is the device end of a single-wire, open-drain bus. It watches a bus input that has already been synchronized to the clock and measures every low period in microseconds. A low period long enough to be a master reset makes the block fire a one-cycle reset strobe. After a fixed wait, the block answers with a presence pulse by enabling its pull-down output for a fixed time. Shorter low periods that start on a master falling edge are treated as write slots. Each one is sampled a fixed time after its falling edge and delivered as a single received bit.

Timing comes from a one-cycle microsecond tick, and only clock cycles with the tick high advance any timer. Received bits are shifted into a byte register, least significant bit first, and a byte strobe marks each completed group of eight bits. Reset detection empties the byte register and restarts the bit count. Falling edges caused by the block's own presence pulse never open a slot. A low period that is too long for a data slot but too short for a reset produces no output at all.

Top module: `owslot_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pull_low`, `bit_valid`, `byte_valid` and `reset_seen` are 0 and `byte_value` is 0.
- R2: A low period that spans at least `RESET_MIN_US` ticks (default 480) gives exactly one single-cycle `reset_seen` strobe, in the cycle after the line is seen high again. Shorter low periods never give one.
- R3: After a reset is detected, `pull_low` is held off for `PRES_DELAY_US` ticks (default 30) and then asserts. With a tick in every cycle, it rises `PRES_DELAY_US + 1` clock cycles after the line returns high.
- R4: The presence pull-down stays asserted for exactly `PRES_WIDTH_US` ticks (default 120).
- R5: Falling edges on the line while a presence reply is pending, being driven, or being released do not start a slot, and they produce no bit.
- R6: A write slot whose low period spans L ticks, counted from the cycle of its falling edge, decodes as 1 when L ≤ `SAMPLE_US` (default 30) and as 0 when `SAMPLE_US` < L ≤ `SLOT_MAX_US` (default 120). Each such slot gives exactly one single-cycle `bit_valid`.
- R7: A low period with `SLOT_MAX_US` < L < `RESET_MIN_US` produces neither a bit nor a reset strobe.
- R8: Received bits enter `byte_value` at bit 7 and shift toward bit 0, so the first bit of a group ends in bit 0. On every eighth bit since the last clear, `byte_valid` pulses for one cycle, and `byte_value` holds the completed byte in that cycle.
- R9: Reset detection clears `byte_value` to 0 and restarts the bit count, so the next byte strobe comes after eight further bits.
- R10: Cycles with `us_tick` low advance no timer. A low period of any length in clock cycles, taken with no tick, produces no reset, no presence pulse and no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| bus_in | input | 1 | Synchronized level of the bus line |
| pull_low | output | 1 | Enables the open-drain pull-down (1 = drive line low) |
| bit_valid | output | 1 | One-cycle strobe for a decoded write slot |
| bit_value | output | 1 | Value of the decoded bit, valid with `bit_valid` |
| byte_valid | output | 1 | One-cycle strobe when eight bits have been collected |
| byte_value | output | 8 | Byte shift register contents |
| reset_seen | output | 1 | One-cycle strobe on detection of a master reset |

## Verification
Two events can land in the same cycle: the slot's sample instant and the rising edge that ends the master's low period. A sweep of low lengths provokes this. When the length equals the sample time exactly, the line returns high in the very cycle the sampler looks at it. That slot must give exactly one strobe carrying a 1, and a pulse one tick longer must give exactly one 0. The sweep continues across the slot limit and the reset limit, and every expected count and bit value is derived from the length alone.

// File: rtl/owslot_pkg.sv
`timescale 1ns/1ps
// Shared state types for the single-wire slave slot decoder.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package owslot_pkg;

    // Presence reply sequencer states
    typedef enum logic [1:0] {
        PR_IDLE,
        PR_WAIT,
        PR_DRIVE,
        PR_RECOVER
    } pres_state_t;

    // Write slot sampler states
    typedef enum logic [1:0] {
        SL_IDLE,
        SL_TIME,
        SL_HOLD
    } slot_state_t;

endpackage

// File: rtl/owslot_line_watch.sv
`timescale 1ns/1ps
// Line watcher: detects edges on the synchronized bus input, measures
// each low period in microsecond ticks, and flags reset-length lows.
// Assumes: bus_in is already synchronized; SLOT_MAX_US < RESET_MIN_US.
module owslot_line_watch #(
    parameter int RESET_MIN_US = 480,
    parameter int SLOT_MAX_US  = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic bus_in,
    output logic fall,
    output logic rise,
    output logic reset_hit,
    output logic short_low,
    output logic reset_seen
);
    localparam int CNT_W = $clog2(RESET_MIN_US + 1);
    localparam logic [CNT_W-1:0] RST_LIM  = CNT_W'(RESET_MIN_US);
    localparam logic [CNT_W-1:0] SLOT_LIM = CNT_W'(SLOT_MAX_US);

    logic             bus_q;
    logic [CNT_W-1:0] low_us;

    // Keep the previous line level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= 1'b1;
        else        bus_q <= bus_in;
    end

    assign fall = bus_q & ~bus_in;
    assign rise = ~bus_q & bus_in;

    // Count ticks spent low since the last falling edge, saturating at the reset limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_us <= '0;
        end else if (fall) begin
            low_us <= CNT_W'(us_tick);
        end else if (!bus_in && us_tick && (low_us != RST_LIM)) begin
            low_us <= low_us + 1'b1;
        end
    end

    assign reset_hit = rise && (low_us >= RST_LIM);
    assign short_low = (low_us <= SLOT_LIM);

    // Register the reset detection into a one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) reset_seen <= 1'b0;
        else        reset_seen <= reset_hit;
    end

    assert_reset_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |=> !reset_seen);

endmodule

// File: rtl/owslot_presence_gen.sv
`timescale 1ns/1ps
// Presence reply sequencer: after a detected reset it waits a fixed
// number of ticks, pulls the line low for a fixed number of ticks, then
// waits for the line to read high again before going idle.
// Assumes: PRES_DELAY_US >= 1, PRES_WIDTH_US >= 1, width below the reset limit.
module owslot_presence_gen
    import owslot_pkg::*;
#(
    parameter int PRES_DELAY_US = 30,
    parameter int PRES_WIDTH_US = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic bus_in,
    input  logic reset_hit,
    output logic pull_low,
    output logic busy
);
    localparam int MAXV = (PRES_DELAY_US > PRES_WIDTH_US) ? PRES_DELAY_US : PRES_WIDTH_US;
    localparam int PC_W = $clog2(MAXV + 1);
    localparam logic [PC_W-1:0] DLY_END = PC_W'(PRES_DELAY_US - 1);
    localparam logic [PC_W-1:0] WID_END = PC_W'(PRES_WIDTH_US - 1);

    pres_state_t     state;
    logic [PC_W-1:0] cnt;

    // Step through wait, drive and release phases of the presence reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PR_IDLE;
            cnt   <= '0;
        end else if (reset_hit) begin
            state <= PR_WAIT;
            cnt   <= '0;
        end else begin
            case (state)
                PR_WAIT: begin
                    if (us_tick) begin
                        if (cnt == DLY_END) begin
                            state <= PR_DRIVE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PR_DRIVE: begin
                    if (us_tick) begin
                        if (cnt == WID_END) begin
                            state <= PR_RECOVER;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PR_RECOVER: begin
                    if (bus_in) state <= PR_IDLE;
                end
                default: state <= PR_IDLE;
            endcase
        end
    end

    assign pull_low = (state == PR_DRIVE);
    assign busy     = (state != PR_IDLE);

    assert_drive_after_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low) |-> ($past(state) == PR_WAIT));

endmodule

// File: rtl/owslot_slot_sampler.sv
`timescale 1ns/1ps
// Write slot sampler: opens a slot on a master falling edge, samples the
// line SAMPLE_US ticks later, and emits one bit. A sampled 0 is held until
// the line rises and is only emitted if the low period was slot-sized.
// Assumes: SAMPLE_US >= 1 and below the slot limit.
module owslot_slot_sampler
    import owslot_pkg::*;
#(
    parameter int SAMPLE_US = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic bus_in,
    input  logic fall,
    input  logic rise,
    input  logic short_low,
    input  logic pres_busy,
    output logic bit_valid,
    output logic bit_value
);
    localparam int SW = $clog2(SAMPLE_US + 1);
    localparam logic [SW-1:0] SMP = SW'(SAMPLE_US);

    slot_state_t   state;
    logic [SW-1:0] slot_us;

    // Time each slot from its falling edge and decide its bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SL_IDLE;
            slot_us   <= '0;
            bit_valid <= 1'b0;
            bit_value <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            case (state)
                SL_IDLE: begin
                    if (fall && !pres_busy) begin
                        state   <= SL_TIME;
                        slot_us <= SW'(us_tick);
                    end
                end
                SL_TIME: begin
                    if (slot_us == SMP) begin
                        if (bus_in) begin
                            bit_valid <= 1'b1;
                            bit_value <= 1'b1;
                            state     <= SL_IDLE;
                        end else begin
                            state <= SL_HOLD;
                        end
                    end else if (us_tick) begin
                        slot_us <= slot_us + 1'b1;
                    end
                end
                SL_HOLD: begin
                    if (rise) begin
                        state <= SL_IDLE;
                        if (short_low) begin
                            bit_valid <= 1'b1;
                            bit_value <= 1'b0;
                        end
                    end
                end
                default: state <= SL_IDLE;
            endcase
        end
    end

    assert_mask_own_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SL_IDLE && pres_busy) |=> (state == SL_IDLE));

    assert_strobe_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    assert_zero_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_value) |-> $past(bus_in));

endmodule

// File: rtl/owslot_byte_shifter.sv
`timescale 1ns/1ps
// Byte shifter: collects received bits LSB first into a BYTE_W-bit register
// and strobes once per full group. A clear empties it and restarts the count.
// Assumes: BYTE_W >= 2; clear has priority over an incoming bit.
module owslot_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_valid,
    input  logic              bit_value,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_value
);
    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sr_next;
    logic [CW-1:0]     cnt;

    // New bit enters at the top; every other position takes its upper neighbour
    for (genvar g = 0; g < BYTE_W; g++) begin : g_shift
        if (g == BYTE_W - 1) begin : g_top
            assign sr_next[g] = bit_value;
        end else begin : g_mid
            assign sr_next[g] = byte_value[g+1];
        end
    end

    // Update the shift register, the bit count and the byte strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            byte_value <= '0;
            cnt        <= '0;
            byte_valid <= 1'b0;
        end else if (bit_valid) begin
            byte_value <= sr_next;
            byte_valid <= (cnt == LAST);
            cnt        <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end else begin
            byte_valid <= 1'b0;
        end
    end

    assert_byte_follows_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(bit_valid));

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (byte_value == '0 && !byte_valid));

endmodule

// File: rtl/owslot_decoder.sv
`timescale 1ns/1ps
// Single-wire slave slot decoder top: ties the line watcher, presence
// reply sequencer, write slot sampler and byte shifter together.
// Assumes: bus_in is synchronized; us_tick is one cycle wide once per us;
// the parameters satisfy SAMPLE_US < SLOT_MAX_US < RESET_MIN_US and
// PRES_WIDTH_US < RESET_MIN_US.
module owslot_decoder #(
    parameter int RESET_MIN_US  = 480,
    parameter int SLOT_MAX_US   = 120,
    parameter int SAMPLE_US     = 30,
    parameter int PRES_DELAY_US = 30,
    parameter int PRES_WIDTH_US = 120,
    parameter int BYTE_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              bus_in,
    output logic              pull_low,
    output logic              bit_valid,
    output logic              bit_value,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_value,
    output logic              reset_seen
);
    logic fall, rise, reset_hit, short_low, pres_busy;

    owslot_line_watch #(
        .RESET_MIN_US (RESET_MIN_US),
        .SLOT_MAX_US  (SLOT_MAX_US)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (us_tick),
        .bus_in     (bus_in),
        .fall       (fall),
        .rise       (rise),
        .reset_hit  (reset_hit),
        .short_low  (short_low),
        .reset_seen (reset_seen)
    );

    owslot_presence_gen #(
        .PRES_DELAY_US (PRES_DELAY_US),
        .PRES_WIDTH_US (PRES_WIDTH_US)
    ) u_pres (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .bus_in    (bus_in),
        .reset_hit (reset_hit),
        .pull_low  (pull_low),
        .busy      (pres_busy)
    );

    owslot_slot_sampler #(
        .SAMPLE_US (SAMPLE_US)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .bus_in    (bus_in),
        .fall      (fall),
        .rise      (rise),
        .short_low (short_low),
        .pres_busy (pres_busy),
        .bit_valid (bit_valid),
        .bit_value (bit_value)
    );

    owslot_byte_shifter #(
        .BYTE_W (BYTE_W)
    ) u_byte (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (reset_hit),
        .bit_valid  (bit_valid),
        .bit_value  (bit_value),
        .byte_valid (byte_valid),
        .byte_value (byte_value)
    );

    assert_no_drive_on_detect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |-> !pull_low);

    assert_no_bit_on_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |-> !bit_valid);

endmodule

// File: tb/sim_owslot_decoder.sv
`timescale 1ns/1ps
// Bench: sweeps master low-pulse lengths across every decode region with a
// small timing configuration and checks counts, values and the byte model.
module sim_owslot_decoder;
    localparam int RST_US = 40;
    localparam int SMAX   = 10;
    localparam int SMP    = 4;
    localparam int PDLY   = 5;
    localparam int PWID   = 16;
    localparam int GAP    = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       m_low = 1'b0;
    logic       pull_low, bit_valid, bit_value, byte_valid, reset_seen;
    logic [7:0] byte_value;
    logic       bus_in;

    assign bus_in = ~(m_low | pull_low);

    always #4 clk = ~clk;

    owslot_decoder #(
        .RESET_MIN_US  (RST_US),
        .SLOT_MAX_US   (SMAX),
        .SAMPLE_US     (SMP),
        .PRES_DELAY_US (PDLY),
        .PRES_WIDTH_US (PWID),
        .BYTE_W        (8)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (tick_en),
        .bus_in     (bus_in),
        .pull_low   (pull_low),
        .bit_valid  (bit_valid),
        .bit_value  (bit_value),
        .byte_valid (byte_valid),
        .byte_value (byte_value),
        .reset_seen (reset_seen)
    );

    int nchk = 0, nfail = 0;
    int cyc = 0;
    int nbits, nbytes, nrst, nplow, first_pl, lastbit, lastbyte;
    int msr = 0, mcnt = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Collect output events at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid)  begin nbits++;  lastbit = int'(bit_value); end
            if (byte_valid) begin nbytes++; lastbyte = int'(byte_value); end
            if (reset_seen) nrst++;
            if (pull_low) begin
                nplow++;
                if (first_pl < 0) first_pl = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one master low pulse of len cycles, then idle, then judge it
    task automatic pulse(input int len, input bit ticks_on);
        int rel;
        bit exp_rst, exp_bit, val;
        nbits = 0; nbytes = 0; nrst = 0; nplow = 0; first_pl = -1;
        @(negedge clk);
        m_low = 1'b1;
        repeat (len) @(negedge clk);
        m_low = 1'b0;
        rel = cyc;
        repeat (GAP) @(negedge clk);
        if (!ticks_on) begin
            // R10: no tick, no timing, whatever the length in cycles
            chk(nrst == 0,  "R10 reset", nrst, 0);
            chk(nplow == 0, "R10 presence", nplow, 0);
            chk(nbits == 0, "R10 bit", nbits, 0);
            return;
        end
        exp_rst = (len >= RST_US);
        exp_bit = (len <= SMAX);
        val     = (len <= SMP);
        chk(nrst == int'(exp_rst), "R2 reset count", nrst, int'(exp_rst));
        chk(nplow == (exp_rst ? PWID : 0), "R4 presence width", nplow, exp_rst ? PWID : 0);
        if (exp_rst) begin
            chk(first_pl - rel == PDLY + 1, "R3 presence delay", first_pl - rel, PDLY + 1);
            chk(nbits == 0, "R5 own pulse bit", nbits, 0);
            chk(byte_value == 8'h00 && nbytes == 0, "R9 cleared", int'(byte_value), 0);
            msr = 0; mcnt = 0;
        end else if (!exp_bit) begin
            chk(nbits == 0, "R7 long low bit", nbits, 0);
            chk(nbytes == 0, "R7 long low byte", nbytes, 0);
        end else begin
            chk(nbits == 1, "R6 strobe count", nbits, 1);
            chk(lastbit == int'(val), "R6 bit value", lastbit, int'(val));
            msr = (msr >> 1) | (int'(val) << 7);
            mcnt++;
            if (mcnt == 8) begin
                chk(nbytes == 1, "R8 byte strobe", nbytes, 1);
                chk(lastbyte == msr, "R8 byte value", lastbyte, msr);
                mcnt = 0;
            end else begin
                chk(nbytes == 0, "R8 no early byte", nbytes, 0);
            end
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) pulse(b[i] ? 2 : 8, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(pull_low == 1'b0 && bit_valid == 1'b0 && byte_valid == 1'b0 && reset_seen == 1'b0,
            "R1 strobes", int'({pull_low, bit_valid, byte_valid, reset_seen}), 0);
        chk(byte_value == 8'h00, "R1 byte", int'(byte_value), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        pulse(RST_US + 5, 1'b1);
        // Sweep every low length across the bit-1, bit-0, discard and reset regions
        for (int len = 1; len <= RST_US + 10; len++) pulse(len, 1'b1);

        // Byte patterns after a reset: counting restarts (R9), LSB-first order (R8)
        pulse(RST_US, 1'b1);
        send_byte(8'hA5);
        send_byte(8'h3C);

        // R10: stalled tick, then a real reset that must leave no stray bit
        tick_en = 1'b0;
        pulse(RST_US * 5, 1'b0);
        tick_en = 1'b1;
        pulse(RST_US + 2, 1'b1);
        send_byte(8'h81);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule